// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a single-clock static memory of 36-bit words. Each word is split into four 9-bit byte lanes. Every control and data input is captured on the rising clock edge. A read issued at one edge delivers its word through an output register one clock later.

Either of two active-low address strobes can start an access. The processor strobe always starts a read. The controller strobe starts a write when any write enable is active and a read otherwise. After a start, an internal 2-bit counter steps the two low address bits on each cycle in which the advance input is low. The order of those steps is either linear or interleaved, chosen by an asynchronous select.

An output enable and a sleep input act without a clock. They gate the read path, and sleep also blocks every new access. Depth is set by the address-width parameter.

Top module: `burst_sram`

## Requirements
- R1: After reset, `dout_en` is 0 and `rdata` is 0, and an advance request with no prior burst start performs no access.
- R2: An access is accepted only while `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0; otherwise both strobes are ignored and memory is not written.
- R3: `strobe_p_n`=0 on a selected edge starts a read of `addr` and ignores every write enable; it takes priority when both strobes are low.
- R4: `strobe_c_n`=0 (with `strobe_p_n`=1) on a selected edge loads `addr` as the burst base and writes the enabled lanes there, or reads that word when no lane is enabled.
- R5: With `bw_en_n`=0, `lane_n[i]`=0 writes bits 9*i+8 down to 9*i (lane 0 is bits 8:0, lane 3 is bits 35:27), and unselected lanes keep their contents; with `bw_en_n`=1 the `lane_n` bits have no effect.
- R6: `gw_n`=0 writes all four lanes, whatever `bw_en_n` and `lane_n` are.
- R7: A word read at edge N appears on `rdata`, with `dout_en`=1, after edge N+1; it is not visible after edge N.
- R8: After a start, `adv_n`=0 with both strobes high steps the 2-bit count by one and performs a read or write at the next burst address. `adv_n`=1 holds the count and performs no access.
- R9: With `order_il`=0, the low two address bits are (base + count) mod 4, so the fifth access of a burst returns to the base.
- R10: With `order_il`=1, the low two address bits are base XOR count.
- R11: `oe_n`=1 forces `rdata` to 0 and `dout_en` to 0 at once, without waiting for a clock.
- R12: While `sleep`=1, no access is accepted, `dout_en` and `rdata` are 0 at once, and stored words are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control and output registers |
| addr | input | ADDR_W | External word address |
| wdata | input | 36 | Write data, four 9-bit lanes |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Second chip enable, active low |
| strobe_p_n | input | 1 | Processor address strobe, read start |
| strobe_c_n | input | 1 | Controller address strobe, read or write start |
| adv_n | input | 1 | Burst advance, active low |
| bw_en_n | input | 1 | Byte-write enable, gates `lane_n` |
| lane_n | input | 4 | Per-lane write enables, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order_il | input | 1 | Asynchronous burst order: 1 interleaved, 0 linear |
| sleep | input | 1 | Asynchronous sleep |
| rdata | output | 36 | Registered read data, 0 when not driven |
| dout_en | output | 1 | High when `rdata` carries a valid read |

## Verification
Lane writes are tried with single-lane, two-lane, all-lane and no-lane enable patterns over a known background word. Each read-back shows which lanes changed, so a lane mapped to the wrong bits or a broken byte-write gate stands out. Global write is run both with the byte controls active and with them inactive, which separates a real override from a write that only happens because the lane enables were set.

Bursts run in both orders from bases whose low bits are not zero. That makes the linear and XOR sequences differ, and four advances show the wraparound. A held advance between two accesses separates counting on every cycle from counting only on advance. Back-to-back pipelined reads show that each word comes out exactly one edge after its address is taken.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  // Low two address bits for burst step cnt from base bits b.
  function automatic logic [1:0] burst_low(input logic [1:0] b,
                                           input logic [1:0] cnt,
                                           input logic il);
    logic [1:0] r;
    if (il) r = b ^ cnt;
    else    r = b + cnt;
    return r;
  endfunction

  // Lanes asked for by the write controls (1 = write that lane).
  function automatic logic [LANES-1:0] lane_request(input logic gw_n,
                                                    input logic bwe_n,
                                                    input logic [LANES-1:0] ln_n);
    logic [LANES-1:0] r;
    if (!gw_n)       r = '1;
    else if (!bwe_n) r = ~ln_n;
    else             r = '0;
    return r;
  endfunction
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_a_n,
  input  logic              ce_b,
  input  logic              ce_c_n,
  input  logic              strobe_p_n,
  input  logic              strobe_c_n,
  input  logic              adv_n,
  input  logic              bw_en_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic              gw_n,
  input  logic              order_il,
  input  logic              sleep,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_rd,
  output logic [LANES-1:0]  wr_lanes,
  output logic              start_p,
  output logic              start_c,
  output logic              adv_step,
  output logic [1:0]        cnt
);
  logic [ADDR_W-1:0] base_q;
  logic              live_q;
  logic              selected;
  logic [1:0]        next_cnt;
  logic [LANES-1:0]  req_lanes;
  logic              touch;

  always_comb begin
    selected  = !sleep && !ce_a_n && ce_b && !ce_c_n;
    start_p   = selected && !strobe_p_n;
    start_c   = selected && strobe_p_n && !strobe_c_n;
    adv_step  = !sleep && live_q && !adv_n && strobe_p_n && strobe_c_n;
    next_cnt  = cnt + 2'd1;
    req_lanes = lane_request(gw_n, bw_en_n, lane_n);
    touch     = start_c || adv_step;
    if (start_p || start_c)
      acc_addr = addr;
    else
      acc_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], next_cnt, order_il)};
    wr_lanes  = touch ? req_lanes : '0;
    acc_rd    = start_p || (touch && (req_lanes == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt    <= '0;
      live_q <= 1'b0;
    end else if (start_p || start_c) begin
      base_q <= addr;
      cnt    <= '0;
      live_q <= 1'b1;
    end else if (adv_step) begin
      cnt    <= next_cnt;
    end
  end
endmodule

// File: rtl/lane_mem.sv
module lane_mem
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lanes[g]) bank[wr_addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rd_word[g*LANE_W +: LANE_W] = bank[rd_addr];
  end
endmodule

// File: rtl/read_pipe.sv
module read_pipe
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_rd,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rvalid,
  output logic [WORD_W-1:0] rdata,
  output logic              dout_en
);
  logic              pend_q;
  logic [WORD_W-1:0] out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      rd_addr <= '0;
      rvalid  <= 1'b0;
      out_q   <= '0;
    end else begin
      pend_q  <= acc_rd;
      rd_addr <= acc_addr;
      rvalid  <= pend_q;
      if (pend_q) out_q <= rd_word;
    end
  end

  assign dout_en = rvalid && !oe_n && !sleep;
  assign rdata   = dout_en ? out_q : '0;
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [35:0]       wdata,
  input  logic              ce_a_n,
  input  logic              ce_b,
  input  logic              ce_c_n,
  input  logic              strobe_p_n,
  input  logic              strobe_c_n,
  input  logic              adv_n,
  input  logic              bw_en_n,
  input  logic [3:0]        lane_n,
  input  logic              gw_n,
  input  logic              oe_n,
  input  logic              order_il,
  input  logic              sleep,
  output logic [35:0]       rdata,
  output logic              dout_en
);
  logic [ADDR_W-1:0] acc_addr;
  logic              acc_rd;
  logic [LANES-1:0]  wr_lanes;
  logic              start_p;
  logic              start_c;
  logic              adv_step;
  logic [1:0]        cnt;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_word;
  logic              rvalid;

  burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
    .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n), .adv_n(adv_n),
    .bw_en_n(bw_en_n), .lane_n(lane_n), .gw_n(gw_n),
    .order_il(order_il), .sleep(sleep),
    .acc_addr(acc_addr), .acc_rd(acc_rd), .wr_lanes(wr_lanes),
    .start_p(start_p), .start_c(start_c), .adv_step(adv_step), .cnt(cnt)
  );

  lane_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .wr_lanes(wr_lanes), .wr_addr(acc_addr), .wdata(wdata),
    .rd_addr(rd_addr), .rd_word(rd_word)
  );

  read_pipe #(.ADDR_W(ADDR_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_addr(acc_addr),
    .rd_word(rd_word), .oe_n(oe_n), .sleep(sleep),
    .rd_addr(rd_addr), .rvalid(rvalid), .rdata(rdata), .dout_en(dout_en)
  );
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep,
  input logic       oe_n,
  input logic       acc_rd,
  input logic [3:0] wr_lanes,
  input logic       start_p,
  input logic       start_c,
  input logic       adv_step,
  input logic [1:0] cnt,
  input logic       rvalid,
  input logic       dout_en
);
  // R3
  strobe_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |-> !start_c);

  // R4
  start_clears_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p || start_c) |=> (cnt == 2'd0));

  // R8
  advance_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_step && !start_p && !start_c) |=> (cnt == $past(cnt) + 2'd1));

  // R8
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_step && !start_p && !start_c) |=> $stable(cnt));

  // R7
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |-> ##2 rvalid);

  // R11
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  // R12
  sleep_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!acc_rd && (wr_lanes == 4'd0) && !dout_en));
endmodule

bind burst_sram burst_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .oe_n(oe_n),
  .acc_rd(acc_rd), .wr_lanes(wr_lanes), .start_p(start_p), .start_c(start_c),
  .adv_step(adv_step), .cnt(cnt), .rvalid(rvalid), .dout_en(dout_en)
);

// File: tb/burst_sram_tb.sv
`timescale 1ns/1ps
module burst_sram_tb;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [35:0]   wdata = '0;
  logic ce_a_n = 1'b0, ce_b = 1'b1, ce_c_n = 1'b0;
  logic strobe_p_n = 1'b1, strobe_c_n = 1'b1, adv_n = 1'b1;
  logic bw_en_n = 1'b1, gw_n = 1'b1, oe_n = 1'b0, order_il = 1'b0, sleep = 1'b0;
  logic [3:0]  lane_n = 4'hF;
  logic [35:0] rdata;
  logic        dout_en;

  int total = 0;
  int fails = 0;
  logic [35:0] model [256];

  always #2 clk = ~clk;

  burst_sram #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
    .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n), .adv_n(adv_n),
    .bw_en_n(bw_en_n), .lane_n(lane_n), .gw_n(gw_n), .oe_n(oe_n),
    .order_il(order_il), .sleep(sleep), .rdata(rdata), .dout_en(dout_en)
  );

  typedef struct packed {
    logic [7:0]  a;
    logic [35:0] bg;
    logic [35:0] d;
    logic [3:0]  ln;
    logic        bwe;
    logic        gw;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{8'h05, 36'h000000000, 36'hFFFFFFFFF, 4'b1110, 1'b0, 1'b1},
    '{8'h06, 36'h123456789, 36'hABCDEF012, 4'b0101, 1'b0, 1'b1},
    '{8'h07, 36'h0F0F0F0F0, 36'h111111111, 4'b0000, 1'b1, 1'b1},
    '{8'h08, 36'h222222222, 36'h9A5A5A5A5, 4'b1111, 1'b0, 1'b0},
    '{8'h09, 36'h333333333, 36'h5C3C3C3C3, 4'b0000, 1'b1, 1'b0},
    '{8'h0A, 36'h444444444, 36'hEEEEEEEEE, 4'b0111, 1'b0, 1'b1},
    '{8'h0B, 36'h555555555, 36'h0000000AB, 4'b1011, 1'b0, 1'b1},
    '{8'h0C, 36'h666666666, 36'h876543210, 4'b1101, 1'b0, 1'b1}
  };

  task automatic check(input bit ok, input string tag,
                       input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    strobe_p_n = 1'b1; strobe_c_n = 1'b1; adv_n = 1'b1;
    bw_en_n = 1'b1; lane_n = 4'hF; gw_n = 1'b1;
    ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
  endtask

  // Bench view of lane merging: walk the bits, lane = bit / 9.
  function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] d,
                                        input logic [3:0] ln, input logic bwe,
                                        input logic gw);
    logic [35:0] r = old;
    for (int b = 0; b < 36; b++)
      if (gw == 1'b0 || (bwe == 1'b0 && ln[b/9] == 1'b0)) r[b] = d[b];
    return r;
  endfunction

  function automatic logic [7:0] lin_addr(input logic [7:0] b, input int k);
    int lo = (int'(b[1:0]) + k) % 4;
    return {b[7:2], 2'(lo)};
  endfunction

  function automatic logic [7:0] il_addr(input logic [7:0] b, input int k);
    return {b[7:2], b[1:0] ^ 2'(k)};
  endfunction

  task automatic full_write(input logic [7:0] a, input logic [35:0] d);
    addr = a; wdata = d; gw_n = 1'b0; strobe_c_n = 1'b0;
    cyc();
    idle();
    model[a] = d;
  endtask

  task automatic read_check(input logic [7:0] a, input string tag);
    addr = a; strobe_p_n = 1'b0;
    cyc();
    idle();
    cyc();
    check(dout_en === 1'b1 && rdata === model[a], tag, rdata, model[a]);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(dout_en === 1'b0 && rdata === 36'd0, "R1 reset outputs", rdata, 36'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: advance before any start makes no access
    adv_n = 1'b0;
    cyc();
    idle();
    cyc();
    check(dout_en === 1'b0, "R1 advance without start", {35'd0, dout_en}, 36'd0);

    // R4 R5 R6: lane-pattern table
    for (int i = 0; i < 8; i++) begin
      vec_t v = VEC[i];
      full_write(v.a, v.bg);
      addr = v.a; wdata = v.d; lane_n = v.ln; bw_en_n = v.bwe; gw_n = v.gw;
      strobe_c_n = 1'b0;
      cyc();
      idle();
      model[v.a] = merge(v.bg, v.d, v.ln, v.bwe, v.gw);
      read_check(v.a, $sformatf("R5 R6 lane table entry %0d", i));
    end

    // R7: one-cycle output latency, not visible at the issue edge
    full_write(8'h60, 36'hCAFE01234);
    addr = 8'h60; strobe_p_n = 1'b0;
    cyc();
    idle();
    check(dout_en === 1'b0, "R7 not valid after issue edge", {35'd0, dout_en}, 36'd0);
    cyc();
    check(dout_en === 1'b1 && rdata === model[8'h60], "R7 valid one edge later",
          rdata, model[8'h60]);

    // R8 R9: linear write burst with wraparound
    order_il = 1'b0;
    addr = 8'h21; wdata = 36'h100000000; gw_n = 1'b0; strobe_c_n = 1'b0;
    model[8'h21] = 36'h100000000;
    cyc();
    strobe_c_n = 1'b1; adv_n = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      wdata = 36'h100000000 + 36'(k);
      model[lin_addr(8'h21, k)] = wdata;
      cyc();
    end
    idle();
    read_check(8'h21, "R9 linear wrap back to base");
    read_check(8'h22, "R9 linear step 1");
    read_check(8'h23, "R9 linear step 2");
    read_check(8'h20, "R9 linear step 3");

    // R10: interleaved pipelined read burst
    for (int k = 0; k < 4; k++) full_write(il_addr(8'h22, k), 36'h700000000 + 36'(k * 17));
    order_il = 1'b1;
    addr = 8'h22; strobe_p_n = 1'b0;
    cyc();
    strobe_p_n = 1'b1; adv_n = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      cyc();
      check(dout_en === 1'b1 && rdata === model[il_addr(8'h22, k - 1)],
            $sformatf("R10 interleaved step %0d", k - 1), rdata, model[il_addr(8'h22, k - 1)]);
    end
    idle();
    cyc();
    check(rdata === model[8'h22], "R10 interleaved wrap", rdata, model[8'h22]);
    order_il = 1'b0;

    // R8: held advance makes no access and keeps the count
    full_write(8'h30, 36'hA00000030);
    full_write(8'h31, 36'hA00000031);
    addr = 8'h30; strobe_p_n = 1'b0;
    cyc();
    idle();
    cyc();
    check(rdata === model[8'h30], "R8 burst base read", rdata, model[8'h30]);
    cyc();
    check(dout_en === 1'b0, "R8 held advance no access", {35'd0, dout_en}, 36'd0);
    adv_n = 1'b0;
    cyc();
    idle();
    cyc();
    check(rdata === model[8'h31], "R8 advance after hold", rdata, model[8'h31]);

    // R2: deselected strobes are ignored
    full_write(8'h40, 36'h0BEEF0040);
    ce_b = 1'b0; addr = 8'h40; wdata = 36'hFFFFFFFFF; gw_n = 1'b0; strobe_c_n = 1'b0;
    cyc();
    idle();
    ce_a_n = 1'b1; addr = 8'h40; strobe_p_n = 1'b0;
    cyc();
    idle();
    cyc();
    check(dout_en === 1'b0, "R2 deselected read ignored", {35'd0, dout_en}, 36'd0);
    read_check(8'h40, "R2 deselected write ignored");

    // R3: processor strobe ignores write enables, wins over controller strobe
    full_write(8'h41, 36'h012340041);
    addr = 8'h41; wdata = 36'h999999999; gw_n = 1'b0; bw_en_n = 1'b0; lane_n = 4'h0;
    strobe_p_n = 1'b0; strobe_c_n = 1'b0;
    cyc();
    idle();
    cyc();
    check(rdata === model[8'h41], "R3 processor start reads", rdata, model[8'h41]);
    read_check(8'h41, "R3 no write on processor start");

    // R12: sleep blocks accesses, keeps contents
    full_write(8'h50, 36'h5EE550050);
    sleep = 1'b1; addr = 8'h50; wdata = 36'h000000001; gw_n = 1'b0; strobe_c_n = 1'b0;
    cyc();
    idle();
    addr = 8'h50; strobe_p_n = 1'b0;
    cyc();
    idle();
    cyc();
    check(dout_en === 1'b0 && rdata === 36'd0, "R12 sleep blocks access", rdata, 36'd0);
    sleep = 1'b0;
    read_check(8'h50, "R12 contents kept through sleep");

    // R11 R12: asynchronous output gating
    addr = 8'h50; strobe_p_n = 1'b0;
    cyc();
    idle();
    cyc();
    oe_n = 1'b1;
    #0.5;
    check(dout_en === 1'b0 && rdata === 36'd0, "R11 oe high gates output", rdata, 36'd0);
    oe_n = 1'b0;
    #0.5;
    check(rdata === model[8'h50], "R11 oe low drives output", rdata, model[8'h50]);
    sleep = 1'b1;
    #0.5;
    check(rdata === 36'd0 && dout_en === 1'b0, "R12 sleep gates output", rdata, 36'd0);
    sleep = 1'b0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule